// File: doc/BRIEF.md
# Channel-Routed Mailbox Dispatcher

The dispatcher sits between a processor register port and a set of child channels. A processor write to the outbound window carries a channel number in the low four bits of its data word. For each write the block picks one of two paths. If the target channel is idle, the whole 32-bit word goes straight to that channel with a one-cycle strobe. If the target channel reports pending work, the word is parked in an outbound queue. A separate drain stream outside this block empties that queue. Words in the queue are never retried automatically.

On the return path, each channel raises an "available" flag while it holds a response. Each cycle the dispatcher picks the lowest-numbered available channel and offers that channel's word on a valid/ready stream toward the inbound queue. It fetches the word with a read strobe only when the stream is accepted. Because the scan starts again from channel 0 every cycle, lower-numbered channels always win.

Back-pressure rules:
- The host write port takes a word whenever `wr_ready` is high, which is every cycle out of reset.
- `in_valid` and `in_data` follow the available flags and do not depend on `in_ready`.
- A channel is consumed only in a cycle where `in_valid` and `in_ready` are both high.
- The outbound drain stream holds `ob_valid` and `ob_data` until `ob_ready` pops the entry.

Top module: `mbx_dispatch`

## Requirements
- R1: A host write (`wr_valid` high while `wr_ready` is high) is decoded as outbound only at byte addresses 0xA0, 0xA4, 0xA8 and 0xAC. Any other address, including unaligned ones such as 0xA2 or 0xB8, has no effect.
- R2: The target channel is `wr_data[3:0]`. A value at or above the channel count NCH (default 9) discards the word: there is no strobe and nothing is queued.
- R3: For an outbound write to an idle channel k (`ch_busy[k]` low), `ch_wr_stb` equals one-hot bit k for exactly the cycle after the accepting clock edge. In that cycle `ch_wr_data` carries the full 32-bit word.
- R4: For an outbound write to a busy channel, the word is appended to the outbound queue and no channel strobe is raised.
- R5: When the outbound queue is full, an outbound write is dropped. Nothing is forwarded and the queue does not change.
- R6: In `ob_status`, bit 31 is full, bit 30 is empty, bits 7:0 hold the queue occupancy, and all other bits are 0. The register updates in the cycle after a push or pop edge.
- R7: The outbound drain stream presents queued words in write order. `ob_valid` is high exactly when the queue is non-empty, and an entry pops on an edge where `ob_valid` and `ob_ready` are both high.
- R8: In each cycle the lowest-indexed channel with `ch_avail` set is selected. Its `ch_rd_data` word appears on `in_data` with `in_valid` high, and `ch_rd_stb` is one-hot on that channel when `in_ready` is high. At most one word moves per cycle.
- R9: While `in_ready` is low, no `ch_rd_stb` bit is raised.
- R10: While `rst_n` is low, every available flag is treated as clear (`in_valid` low, no read strobe). Reset empties the outbound queue and clears the write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write valid |
| wr_ready | output | 1 | Host write ready (high out of reset) |
| wr_addr | input | 8 | Host write byte address |
| wr_data | input | 32 | Host write data; bits 3:0 select the channel |
| ch_busy | input | NCH | Per-channel pending-work flag |
| ch_wr_stb | output | NCH | One-cycle delivery strobe per channel |
| ch_wr_data | output | 32 | Word delivered to the strobed channel |
| ch_avail | input | NCH | Per-channel response-available flag |
| ch_rd_stb | output | NCH | One-hot fetch strobe to the selected channel |
| ch_rd_data | input | NCH*32 | Response words, channel k at bits 32k+31:32k |
| in_valid | output | 1 | Inbound stream valid |
| in_ready | input | 1 | Inbound stream ready (low when inbound queue full) |
| in_data | output | 32 | Inbound stream word |
| ob_valid | output | 1 | Outbound queue head valid |
| ob_ready | input | 1 | Outbound drain accepts head |
| ob_data | output | 32 | Outbound queue head word |
| ob_status | output | 32 | Outbound queue status word |

## Verification
Results arrive on two timings, and the checks follow each one.

Delivery strobes, delivered data and the status word are registered. They are due one cycle after the edge that accepts the write. The bench drives each write at a falling edge and samples just after the following rising edge. It checks again after the next edge to confirm the strobe lasts exactly one cycle.

The response scan is combinational. Its selection, `in_data` and the read strobe are due in the same cycle the flags are applied. Drain data is checked before the popping edge, and the status word is checked after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int CH_SEL_W  = 4;
  localparam logic [3:0] OB_PAGE = 4'hA;
  localparam int ST_FULL_BIT  = 31;
  localparam int ST_EMPTY_BIT = 30;
  localparam int ST_LEVEL_W   = 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  word_t push_data,
  input  logic  pop_ready,
  output logic  out_valid,
  output word_t out_data,
  output logic  full,
  output logic  empty,
  output logic [ST_LEVEL_W-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  word_t          mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign out_valid = !empty;
  assign out_data  = mem[rp];
  assign level     = ST_LEVEL_W'(cnt);
  assign do_pop    = pop_ready && !empty;
  assign do_push   = push && !full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mbx_wr_route.sv
module mbx_wr_route
  import mbx_pkg::*;
#(
  parameter int NCH = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [7:0]     wr_addr,
  input  word_t          wr_data,
  input  logic [NCH-1:0] ch_busy,
  input  logic           q_full,
  output logic           q_push,
  output logic [NCH-1:0] ch_wr_stb,
  output word_t          ch_wr_data
);
  logic [CH_SEL_W-1:0] ch;
  logic [NCH-1:0]      sel;
  logic                hit, ch_ok, tgt_busy, accept, fwd;

  assign ch = wr_data[CH_SEL_W-1:0];

  // One-hot decode of the target; codes >= NCH leave sel empty
  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++) sel[i] = (ch == CH_SEL_W'(i));
  end

  assign hit      = rst_n && wr_valid && (wr_addr[7:4] == OB_PAGE) && (wr_addr[1:0] == 2'b00);
  assign ch_ok    = |sel;
  assign tgt_busy = |(sel & ch_busy);
  assign accept   = hit && ch_ok && !q_full;
  assign q_push   = accept && tgt_busy;
  assign fwd      = accept && !tgt_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_wr_stb  <= '0;
      ch_wr_data <= '0;
    end else begin
      ch_wr_stb <= fwd ? sel : '0;
      if (fwd) ch_wr_data <= wr_data;
    end
  end
endmodule

// File: rtl/mbx_resp_scan.sv
module mbx_resp_scan
  import mbx_pkg::*;
#(
  parameter int NCH = 9
) (
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_avail,
  input  logic [NCH*WORD_W-1:0] ch_rd_data,
  input  logic                  in_ready,
  output logic [NCH-1:0]        ch_rd_stb,
  output logic                  in_valid,
  output word_t                 in_data
);
  logic [NCH-1:0] avail_g, pick;
  logic           found;

  assign avail_g = rst_n ? ch_avail : '0;

  // Fixed-priority scan from channel 0 upward
  always_comb begin
    pick    = '0;
    found   = 1'b0;
    in_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && avail_g[i]) begin
        found   = 1'b1;
        pick[i] = 1'b1;
        in_data = ch_rd_data[i*WORD_W +: WORD_W];
      end
    end
  end

  assign in_valid  = found;
  assign ch_rd_stb = pick & {NCH{in_ready}};
endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
  import mbx_pkg::*;
#(
  parameter int NCH      = 9,
  parameter int OB_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [7:0]            wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [NCH-1:0]        ch_busy,
  output logic [NCH-1:0]        ch_wr_stb,
  output logic [WORD_W-1:0]     ch_wr_data,
  input  logic [NCH-1:0]        ch_avail,
  output logic [NCH-1:0]        ch_rd_stb,
  input  logic [NCH*WORD_W-1:0] ch_rd_data,
  output logic                  in_valid,
  input  logic                  in_ready,
  output logic [WORD_W-1:0]     in_data,
  output logic                  ob_valid,
  input  logic                  ob_ready,
  output logic [WORD_W-1:0]     ob_data,
  output logic [WORD_W-1:0]     ob_status
);
  logic q_push, q_full, q_empty;
  logic [ST_LEVEL_W-1:0] q_level;

  assign wr_ready = rst_n;

  mbx_wr_route #(.NCH(NCH)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_busy(ch_busy), .q_full(q_full), .q_push(q_push),
    .ch_wr_stb(ch_wr_stb), .ch_wr_data(ch_wr_data)
  );

  mbx_fifo #(.DEPTH(OB_DEPTH)) u_obq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(wr_data),
    .pop_ready(ob_ready), .out_valid(ob_valid), .out_data(ob_data),
    .full(q_full), .empty(q_empty), .level(q_level)
  );

  mbx_resp_scan #(.NCH(NCH)) u_scan (
    .rst_n(rst_n), .ch_avail(ch_avail), .ch_rd_data(ch_rd_data),
    .in_ready(in_ready), .ch_rd_stb(ch_rd_stb), .in_valid(in_valid),
    .in_data(in_data)
  );

  always_comb begin
    ob_status = '0;
    ob_status[ST_FULL_BIT]  = q_full;
    ob_status[ST_EMPTY_BIT] = q_empty;
    ob_status[ST_LEVEL_W-1:0] = q_level;
  end
endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk #(
  parameter int NCH      = 9,
  parameter int OB_DEPTH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] ch_wr_stb,
  input logic [NCH-1:0] ch_avail,
  input logic [NCH-1:0] ch_rd_stb,
  input logic           in_valid,
  input logic           in_ready,
  input logic           ob_ready,
  input logic [31:0]    ob_status
);
  assert_stb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_stb));

  assert_stb_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_wr_stb) |-> $past(wr_valid));

  assert_no_fwd_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_wr_stb) |-> (($past(ch_busy) & ch_wr_stb) == '0));

  assert_full_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_status[31] && !ob_ready) |=> $stable(ob_status));

  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ob_status[31] && ob_status[30]));

  assert_rd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd_stb));

  assert_rd_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_rd_stb) |-> (((ch_rd_stb & ch_avail) == ch_rd_stb) &&
                      ((ch_avail & (ch_rd_stb - 1'b1)) == '0)));

  assert_rd_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_rd_stb) |-> (in_ready && in_valid));
endmodule

bind mbx_dispatch mbx_dispatch_chk #(.NCH(NCH), .OB_DEPTH(OB_DEPTH)) u_chk (.*);

// File: tb/mbx_dispatch_bench.sv
module mbx_dispatch_bench;
  localparam int NCH = 9;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_valid, wr_ready, in_valid, in_ready, ob_valid, ob_ready;
  logic [7:0] wr_addr;
  logic [31:0] wr_data, ch_wr_data, in_data, ob_data, ob_status;
  logic [NCH-1:0] ch_busy, ch_wr_stb, ch_avail, ch_rd_stb;
  logic [NCH*32-1:0] ch_rd_data;

  mbx_dispatch #(.NCH(NCH), .OB_DEPTH(DEPTH)) u_mbx_dispatch (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]     addr;
    logic [31:0]    data;
    logic [NCH-1:0] busy;
    logic [NCH-1:0] stb;
    logic [7:0]     lvl;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'hA0, 32'h1234_5670, 9'h000, 9'h001, 8'd0},  // R3 ch0
    '{8'hA4, 32'hDEAD_BEE8, 9'h000, 9'h100, 8'd0},  // R3 ch8
    '{8'hAC, 32'h0000_0009, 9'h000, 9'h000, 8'd0},  // R2 ch9 rejected
    '{8'hA8, 32'hCAFE_0003, 9'h008, 9'h000, 8'd1},  // R4 queued
    '{8'hA0, 32'h0000_000F, 9'h000, 9'h000, 8'd1},  // R2 ch15 rejected
    '{8'hB8, 32'h0000_0001, 9'h000, 9'h000, 8'd1},  // R1 wrong page
    '{8'hA2, 32'h0000_0001, 9'h000, 9'h000, 8'd1},  // R1 unaligned
    '{8'hA4, 32'h5555_5552, 9'h004, 9'h000, 8'd2},  // R4 queued
    '{8'hAC, 32'h7777_0005, 9'h008, 9'h020, 8'd2}   // R3 other channel busy
  };

  task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic [NCH-1:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; ch_busy = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; ch_busy = '0;
    ch_avail = 9'h024; ch_rd_data = '0; in_ready = 1'b1; ob_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 status in reset", 64'(ob_status), 64'h4000_0000);
    check("R10 in_valid in reset", 64'(in_valid), 64'd0);
    check("R10 rd_stb in reset", 64'(ch_rd_stb), 64'd0);
    ch_avail = '0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 status after reset", 64'(ob_status), 64'h4000_0000);
    check("R1 wr_ready", 64'(wr_ready), 64'd1);

    for (int v = 0; v < 9; v++) begin
      host_write(VEC[v].addr, VEC[v].data, VEC[v].busy);
      check($sformatf("R3 stb vec%0d", v), 64'(ch_wr_stb), 64'(VEC[v].stb));
      if (VEC[v].stb != '0) check($sformatf("R3 data vec%0d", v), 64'(ch_wr_data), 64'(VEC[v].data));
      check($sformatf("R6 level vec%0d", v), 64'(ob_status[7:0]), 64'(VEC[v].lvl));
      @(posedge clk); #1;
      check($sformatf("R3 stb one cycle vec%0d", v), 64'(ch_wr_stb), 64'd0);
    end

    host_write(8'hA0, 32'h1111_0003, 9'h008);
    host_write(8'hA8, 32'h2222_0002, 9'h004);
    check("R6 full status", 64'(ob_status), 64'h8000_0004);
    host_write(8'hA4, 32'h3333_0001, 9'h000);
    check("R5 no forward when full", 64'(ch_wr_stb), 64'd0);
    check("R5 queue unchanged", 64'(ob_status), 64'h8000_0004);

    begin
      logic [31:0] exp_q [4] = '{32'hCAFE_0003, 32'h5555_5552, 32'h1111_0003, 32'h2222_0002};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); ob_ready = 1'b1; #1;
        check("R7 ob_valid", 64'(ob_valid), 64'd1);
        check($sformatf("R7 order %0d", k), 64'(ob_data), 64'(exp_q[k]));
      end
      @(negedge clk); ob_ready = 1'b0; #1;
      check("R7 drained", 64'(ob_valid), 64'd0);
      check("R6 empty status", 64'(ob_status), 64'h4000_0000);
    end

    @(negedge clk);
    ch_rd_data[2*32 +: 32] = 32'hA2A2_A2A2;
    ch_rd_data[5*32 +: 32] = 32'hA5A5_A5A5;
    ch_avail = 9'h024; in_ready = 1'b1; #1;
    check("R8 pick ch2 stb", 64'(ch_rd_stb), 64'h004);
    check("R8 pick ch2 data", 64'(in_data), 64'hA2A2_A2A2);
    @(negedge clk); ch_avail = 9'h120; #1;
    check("R8 pick ch5 stb", 64'(ch_rd_stb), 64'h020);
    check("R8 pick ch5 data", 64'(in_data), 64'hA5A5_A5A5);
    @(negedge clk); in_ready = 1'b0; #1;
    check("R9 no fetch when not ready", 64'(ch_rd_stb), 64'd0);
    check("R9 valid still offered", 64'(in_valid), 64'd1);

    host_write(8'hA0, 32'h4444_0001, 9'h002);
    check("R4 queued before reset", 64'(ob_status), 64'h0000_0001);
    @(negedge clk); rst_n = 1'b0; in_ready = 1'b1; #1;
    check("R10 avail masked", 64'(in_valid), 64'd0);
    check("R10 rd_stb masked", 64'(ch_rd_stb), 64'd0);
    @(posedge clk); #1;
    check("R10 queue emptied", 64'(ob_status), 64'h4000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule